// File: doc/BRIEF.md
# Tagged Receive Collector for an Eight-Line Serial Multiplexer

This block gathers received characters from up to eight serial lines into one shared queue. Each line's deserializer offers a character with framing and parity flags as a one-cycle strobe. The block labels the character with the number of the line it came from and stores it in a 64-entry buffer. Software drains the buffer through a single 16-bit read word. That word carries a data-valid bit, the error flags, the line number and the character. Each read removes one entry, and software keeps reading until the valid bit comes back clear.

Every line has its own receiver-on bit, written through a small per-line configuration port. Characters from a line whose bit is off are discarded. A line break needs no separate status bit: it arrives as a zero character with the framing flag set. A character is lost when it cannot be placed, either because the buffer is full or because the same line still has an unstored character waiting. The loss is reported as an overrun flag on the next entry stored from that line. A receive-done status is raised while the buffer holds data and the master scan enable is on. A receive interrupt follows it, gated by an interrupt-enable input.

Top module: `line_rx_gather`

## Requirements
- R1: The read word is laid out as follows: bit 15 valid, bit 14 overrun, bit 13 framing error, bit 12 parity error, bit 11 zero, bits 10:8 source line, bits 7:0 character. A read strobe returns the oldest entry on `rd_word` after the next clock edge, removes it, and the word holds until the next read.
- R2: A read while the buffer is empty returns the all-zero word, so the valid bit is clear.
- R3: Entries leave in the order they were stored, and the buffer holds exactly DEPTH (64) entries.
- R4: A character is accepted only while its line's receiver-on bit is set. The bit is written through `cfg_wr`/`cfg_line`/`cfg_rx_on` and takes effect after the next edge. All lines are off after reset.
- R5: Characters arriving on several lines in the same cycle are stored in ascending line order, one per clock.
- R6: When a character reaches the buffer while it is full, the character is dropped. The next entry stored from that line carries the overrun bit, and other lines' entries do not.
- R7: A character that arrives on a line whose previous character is still waiting to be stored is dropped. The waiting character is stored with the overrun bit set.
- R8: A break, which is a zero character with the framing flag, is stored unchanged as character 0x00 with bit 13 set.
- R9: `rx_done` is high exactly when, at the previous edge, the buffer was non-empty and `scan_en` was high. A character that arrives in cycle k raises it after edge k+2.
- R10: `rx_irq` is high exactly when, at the previous edge, the conditions for `rx_done` held and `irq_en` was high.
- R11: After reset the buffer is empty, `rd_word` is zero, and `rx_done` and `rx_irq` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | Master scan enable, gates receive-done |
| irq_en | input | 1 | Receive interrupt enable |
| cfg_wr | input | 1 | Write strobe for a line's receiver-on bit |
| cfg_line | input | 3 | Line addressed by the configuration write |
| cfg_rx_on | input | 1 | Value written to the receiver-on bit |
| ln_vld | input | NUM_LINES | Per-line character strobe |
| ln_char | input | 8*NUM_LINES | Per-line character, line i in bits 8i+7:8i |
| ln_ferr | input | NUM_LINES | Per-line framing-error flag |
| ln_perr | input | NUM_LINES | Per-line parity-error flag |
| rd_en | input | 1 | Read-and-remove strobe |
| rd_word | output | 16 | Registered read word |
| rx_done | output | 1 | Buffer holds data while scanning |
| rx_irq | output | 1 | Receive interrupt |

## Verification
A strobe sampled at edge k places the character in its line's holding slot. If the line wins arbitration, the character is written to the buffer at edge k+1, and `rx_done`/`rx_irq` rise after edge k+2. A read strobe sampled at edge j presents its word after edge j, and status drops after edge j+1. Each of the bench's checks waits out that count of edges before sampling on the falling edge: at least one idle cycle between an arrival and its read, and both sides of the done edge are probed. Simultaneous arrivals are read back only after one cycle per competing line has passed, so the check sees both the ordering and the overrun flags.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  localparam int LINE_W = 3;
  localparam int CHAR_W = 8;
  localparam int WORD_W = 16;

  // stored entry, word bit 15 (valid) is added at the read port
  typedef struct packed {
    logic              ovr;
    logic              fe;
    logic              pe;
    logic              rsv;
    logic [LINE_W-1:0] line;
    logic [CHAR_W-1:0] ch;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);
endpackage

// File: rtl/rxc_slot.sv
module rxc_slot
  import rxc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_on,
  input  logic              arr_vld,
  input  logic [CHAR_W-1:0] arr_ch,
  input  logic              arr_fe,
  input  logic              arr_pe,
  input  logic              grant,
  input  logic              full,
  output logic              pend,
  output logic [CHAR_W-1:0] hold_ch,
  output logic              hold_fe,
  output logic              hold_pe,
  output logic              hold_ovr
);
  logic              pend_q, ovr_q, fe_q, pe_q;
  logic [CHAR_W-1:0] ch_q;
  logic              accept, take, lose_busy, lose_full, stored;

  assign accept    = arr_vld && rx_on;
  assign take      = accept && (!pend_q || grant);
  assign lose_busy = accept && pend_q && !grant;
  assign lose_full = grant && full;
  assign stored    = grant && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
      ch_q   <= '0;
      fe_q   <= 1'b0;
      pe_q   <= 1'b0;
    end else begin
      if (take) begin
        pend_q <= 1'b1;
        ch_q   <= arr_ch;
        fe_q   <= arr_fe;
        pe_q   <= arr_pe;
      end else if (grant) begin
        pend_q <= 1'b0;
      end
      if (lose_busy || lose_full)
        ovr_q <= 1'b1;
      else if (stored)
        ovr_q <= 1'b0;
    end
  end

  assign pend     = pend_q;
  assign hold_ch  = ch_q;
  assign hold_fe  = fe_q;
  assign hold_pe  = pe_q;
  assign hold_ovr = ovr_q;
endmodule

// File: rtl/rxc_pick.sv
module rxc_pick
  import rxc_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]      req,
  output logic [N-1:0]      gnt,
  output logic [LINE_W-1:0] idx
);
  always_comb begin
    gnt = '0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = LINE_W'(i);
      end
    end
  end
endmodule

// File: rtl/rxc_fifo.sv
module rxc_fifo #(
  parameter int W     = 15,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          rd_req,
  output logic          full,
  output logic [CW-1:0] cnt,
  output logic          out_vld,
  output logic [W-1:0]  out_data
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt_q;
  logic          pop;

  assign full = (cnt_q == CW'(DEPTH));
  assign pop  = rd_req && (cnt_q != '0);
  assign cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wptr <= wptr + AW'(1);
      if (pop)  rptr <= rptr + AW'(1);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_data <= '0;
    end else if (rd_req) begin
      out_vld  <= pop;
      out_data <= pop ? mem[rptr] : '0;
    end
  end
endmodule

// File: rtl/line_rx_gather.sv
module line_rx_gather
  import rxc_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DEPTH     = 64,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        scan_en,
  input  logic                        irq_en,
  input  logic                        cfg_wr,
  input  logic [LINE_W-1:0]           cfg_line,
  input  logic                        cfg_rx_on,
  input  logic [NUM_LINES-1:0]        ln_vld,
  input  logic [NUM_LINES*CHAR_W-1:0] ln_char,
  input  logic [NUM_LINES-1:0]        ln_ferr,
  input  logic [NUM_LINES-1:0]        ln_perr,
  input  logic                        rd_en,
  output logic [WORD_W-1:0]           rd_word,
  output logic                        rx_done,
  output logic                        rx_irq
);
  logic [NUM_LINES-1:0] rx_on_q, pend, gnt, h_fe, h_pe, h_ovr;
  logic [CHAR_W-1:0]    h_ch [NUM_LINES];
  logic [LINE_W-1:0]    gnt_idx;
  logic                 full, push, out_vld, done_q, irq_q;
  logic [CNT_W-1:0]     fill_cnt;
  rx_entry_t            wr_entry, out_entry;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst)
        rx_on_q[g] <= 1'b0;
      else if (cfg_wr && cfg_line == LINE_W'(g))
        rx_on_q[g] <= cfg_rx_on;
    end

    rxc_slot u_slot (
      .clk      (clk),
      .rst      (rst),
      .rx_on    (rx_on_q[g]),
      .arr_vld  (ln_vld[g]),
      .arr_ch   (ln_char[g*CHAR_W +: CHAR_W]),
      .arr_fe   (ln_ferr[g]),
      .arr_pe   (ln_perr[g]),
      .grant    (gnt[g]),
      .full     (full),
      .pend     (pend[g]),
      .hold_ch  (h_ch[g]),
      .hold_fe  (h_fe[g]),
      .hold_pe  (h_pe[g]),
      .hold_ovr (h_ovr[g])
    );
  end

  rxc_pick #(.N(NUM_LINES)) u_pick (
    .req (pend),
    .gnt (gnt),
    .idx (gnt_idx)
  );

  always_comb begin
    wr_entry      = '0;
    wr_entry.line = gnt_idx;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (gnt[i]) begin
        wr_entry.ch  = h_ch[i];
        wr_entry.fe  = h_fe[i];
        wr_entry.pe  = h_pe[i];
        wr_entry.ovr = h_ovr[i];
      end
    end
  end

  assign push = (|gnt) && !full;

  rxc_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .din      (wr_entry),
    .rd_req   (rd_en),
    .full     (full),
    .cnt      (fill_cnt),
    .out_vld  (out_vld),
    .out_data (out_entry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      done_q <= (fill_cnt != '0) && scan_en;
      irq_q  <= (fill_cnt != '0) && scan_en && irq_en;
    end
  end

  assign rd_word = {out_vld, out_entry};
  assign rx_done = done_q;
  assign rx_irq  = irq_q;
endmodule

// File: rtl/rxc_checker.sv
module rxc_checker #(
  parameter int NUM_LINES = 8,
  parameter int DEPTH     = 64,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 scan_en,
  input logic                 irq_en,
  input logic                 rd_en,
  input logic [15:0]          rd_word,
  input logic                 rx_done,
  input logic                 rx_irq,
  input logic [CNT_W-1:0]     fill_cnt,
  input logic [NUM_LINES-1:0] gnt,
  input logic                 push,
  input logic                 full
);
  p_capacity_r3: assert property (@(posedge clk) disable iff (rst)
    fill_cnt <= CNT_W'(DEPTH));

  p_one_grant_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    full |-> !push);

  p_empty_read_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && fill_cnt == '0) |=> (rd_word == 16'h0000));

  p_read_valid_r1: assert property (@(posedge clk) disable iff (rst)
    (rd_en && fill_cnt != '0) |=> rd_word[15]);

  p_done_scan_r9: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> $past(scan_en));

  p_irq_done_r10: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> rx_done);

  p_irq_enable_r10: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> $past(irq_en));
endmodule

bind line_rx_gather rxc_checker #(.NUM_LINES(NUM_LINES), .DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .scan_en  (scan_en),
  .irq_en   (irq_en),
  .rd_en    (rd_en),
  .rd_word  (rd_word),
  .rx_done  (rx_done),
  .rx_irq   (rx_irq),
  .fill_cnt (fill_cnt),
  .gnt      (gnt),
  .push     (push),
  .full     (full)
);

// File: tb/sim_line_rx_gather.sv
`timescale 1ns/1ps
module sim_line_rx_gather;
  localparam int NL = 8;
  localparam int DP = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          scan_en = 1'b0, irq_en = 1'b0;
  logic          cfg_wr = 1'b0, cfg_rx_on = 1'b0;
  logic [2:0]    cfg_line = '0;
  logic [NL-1:0] ln_vld = '0, ln_ferr = '0, ln_perr = '0;
  logic [NL*8-1:0] ln_char = '0;
  logic          rd_en = 1'b0;
  logic [15:0]   rd_word;
  logic          rx_done, rx_irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  line_rx_gather #(.NUM_LINES(NL), .DEPTH(DP)) u0 (
    .clk(clk), .rst(rst), .scan_en(scan_en), .irq_en(irq_en),
    .cfg_wr(cfg_wr), .cfg_line(cfg_line), .cfg_rx_on(cfg_rx_on),
    .ln_vld(ln_vld), .ln_char(ln_char), .ln_ferr(ln_ferr), .ln_perr(ln_perr),
    .rd_en(rd_en), .rd_word(rd_word), .rx_done(rx_done), .rx_irq(rx_irq)
  );

  // stimulus word: bit13 framing, bit12 parity, 10:8 line, 7:0 char
  localparam logic [15:0] VEC [6] = '{
    16'h0041, 16'h0345, 16'h2700, 16'h1212, 16'h2155, 16'h30FF
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input int l, input logic [7:0] c, input logic fe, input logic pe);
    ln_vld[l]        = 1'b1;
    ln_char[l*8 +: 8] = c;
    ln_ferr[l]       = fe;
    ln_perr[l]       = pe;
  endtask

  task automatic strobe();
    @(negedge clk);
    ln_vld = '0; ln_ferr = '0; ln_perr = '0; ln_char = '0;
  endtask

  task automatic rd(output logic [15:0] w);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    w = rd_word;
  endtask

  task automatic cfg(input int l, input logic on);
    cfg_wr = 1'b1; cfg_line = 3'(l); cfg_rx_on = on;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R11 reset state
    chk("R11 rd_word", rd_word, 16'h0000);
    chk("R11 done", {15'b0, rx_done}, 16'h0);
    chk("R11 irq", {15'b0, rx_irq}, 16'h0);
    // R4 line off after reset: arrival ignored
    put(2, 8'h5A, 1'b0, 1'b0); strobe(); cyc(2);
    rd(w); chk("R4 off after reset", w, 16'h0000);
    // R2 empty read
    rd(w); chk("R2 empty read", w, 16'h0000);

    for (int i = 0; i < NL; i++) cfg(i, 1'b1);
    scan_en = 1'b1;

    // table walk: R1 format, R8 break
    for (int i = 0; i < 6; i++) begin
      put(int'(VEC[i][10:8]), VEC[i][7:0], VEC[i][13], VEC[i][12]);
      strobe();
      cyc(1);
      rd(w);
      chk((VEC[i][13] && VEC[i][7:0] == 8'h00) ? "R8 break entry" : "R1 entry word",
          w, VEC[i] | 16'h8000);
    end
    rd(w); chk("R1 drained", w, 16'h0000);

    // R9 / R10 timing
    put(4, 8'h44, 1'b0, 1'b0); strobe();
    cyc(1); chk("R9 done not yet", {15'b0, rx_done}, 16'h0);
    cyc(1); chk("R9 done after two edges", {15'b0, rx_done}, 16'h1);
    chk("R10 irq masked", {15'b0, rx_irq}, 16'h0);
    irq_en = 1'b1; cyc(1);
    chk("R10 irq enabled", {15'b0, rx_irq}, 16'h1);
    scan_en = 1'b0; cyc(1);
    chk("R9 scan off", {15'b0, rx_done}, 16'h0);
    chk("R10 irq follows done", {15'b0, rx_irq}, 16'h0);
    scan_en = 1'b1; cyc(1);
    rd(w); chk("R1 held word", w, 16'h8444);
    chk("R1 word holds", rd_word, 16'h8444);
    cyc(1); chk("R9 done drops", {15'b0, rx_done}, 16'h0);
    irq_en = 1'b0;

    // R5 simultaneous arrivals on all lines
    for (int i = 0; i < NL; i++) put(i, 8'(8'h10 + i), 1'b0, 1'b0);
    strobe(); cyc(NL + 1);
    for (int i = 0; i < NL; i++) begin
      rd(w);
      chk("R5 ascending order", w, 16'h8000 | 16'(i << 8) | 16'(8'h10 + i));
    end

    // R7 arrival on a line still waiting
    put(0, 8'h20, 1'b0, 1'b0); put(1, 8'h21, 1'b0, 1'b0); strobe();
    put(1, 8'h22, 1'b0, 1'b0); strobe();
    cyc(2);
    rd(w); chk("R7 other line clean", w, 16'h8020);
    rd(w); chk("R7 waiting char with overrun", w, 16'hC121);
    rd(w); chk("R7 new char dropped", w, 16'h0000);

    // R4 disabled line ignored
    cfg(5, 1'b0);
    put(5, 8'h55, 1'b0, 1'b0); strobe(); cyc(2);
    chk("R4 no done", {15'b0, rx_done}, 16'h0);
    rd(w); chk("R4 disabled line", w, 16'h0000);
    cfg(5, 1'b1);

    // R3 / R6 full buffer
    for (int i = 0; i < DP; i++) begin
      put(0, 8'(i), 1'b0, 1'b0);
      @(negedge clk);
    end
    ln_vld = '0; ln_char = '0;
    cyc(2);
    put(0, 8'hEE, 1'b0, 1'b0); strobe(); cyc(2);
    rd(w); chk("R3 first in", w, 16'h8000);
    rd(w); chk("R3 second", w, 16'h8001);
    put(0, 8'hAA, 1'b0, 1'b0); put(3, 8'h33, 1'b0, 1'b0); strobe(); cyc(3);
    for (int i = 2; i < DP; i++) begin
      rd(w); chk("R3 fifo order", w, 16'h8000 | 16'(i));
    end
    rd(w); chk("R6 overrun after full", w, 16'hC0AA);
    rd(w); chk("R6 other line no overrun", w, 16'h8333);
    rd(w); chk("R6 dropped char absent", w, 16'h0000);

    finished = 1;
    summary();
    $finish;
  end
endmodule